// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Controller

This block collects a wide set of interrupt request sources into ten shared vectors and decides which of them, if any, should interrupt the processor. Each source is gated by its own enable. A vector counts as pending when any of its enabled sources has its flag set. Each vector carries a two-bit priority setting that maps onto one of three levels: low, high or highest. The vector entry addresses begin at 03h and are spaced eight bytes apart.

The controller raises its request only when the best pending vector outranks the level now in service. When the processor acknowledges, the winning level is pushed onto a small in-service stack and the vector address is latched. A return-from-interrupt pulse pops the stack and restores the level that was active before. Source flags are left untouched: software clears them.

Top module: `irq_level_arbiter`

## Requirements
- R1: Vector v has entry address VEC_BASE + VEC_STRIDE*v. With the default parameters this is 03h, 0Bh, 13h and so on up to 4Bh. `req_addr` shows the address of the winning pending vector while `irq` is high.
- R2: Source s belongs to vector s / SRC_PER_VEC. A vector is pending only when at least one of its sources has both `src_flag` and `src_en` set.
- R3: The field `vec_level[2v+1:2v]` sets the level of vector v. Code 0 is low, code 1 is high, and codes 2 and 3 are both highest. Among pending vectors, the one with the highest level wins.
- R4: Among pending vectors that share the highest level, the vector with the smallest index (lowest address) wins.
- R5: `irq` is high only when the winner's level is strictly above `cur_level`. `cur_level` is 0 when nothing is in service, and otherwise 1, 2 or 3 for low, high or highest. A request at a level equal to or below the level in service is held off.
- R6: An `ack` taken while `irq` is high does three things from the next cycle. It pushes the winner's level so that `cur_level` shows it. It increments `depth`. It loads `svc_addr` with the winner's address. Source flags are not cleared, so the acknowledged vector stays pending.
- R7: A `reti` while `depth` is nonzero pops the stack, and `cur_level` returns to the level that was in service before. A `reti` at depth 0 has no effect.
- R8: An `ack` while `irq` is low changes neither `depth`, `cur_level` nor `svc_addr`.
- R9: When `ack` and `reti` arrive in the same cycle, only the `reti` is performed.
- R10: After reset, `depth`, `cur_level` and `svc_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_flag | input | NUM_VEC*SRC_PER_VEC | Per-source request flags |
| src_en | input | NUM_VEC*SRC_PER_VEC | Per-source enables |
| vec_level | input | 2*NUM_VEC | Per-vector level code |
| ack | input | 1 | Processor acknowledge strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| irq | output | 1 | Interrupt request to the processor |
| req_addr | output | ADDR_W | Address of the current winning vector |
| svc_addr | output | ADDR_W | Address latched at the last accepted acknowledge |
| cur_level | output | 2 | Level now in service (0 means none) |
| depth | output | DEPTH_W | Number of nested interrupts in service |

## Verification
The hardest state to reach from the ports is a full stack: three nested services, each strictly above the one below, with lower vectors still pending because their flags are never cleared. The stimulus reaches it by enabling one source per level in rising order and acknowledging each in turn. It then tests blocked requests, an idle acknowledge, a coincident acknowledge and return, and unwinding by return pulses down to an extra return at depth zero.

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter #(
  parameter int NUM_VEC     = 10,
  parameter int SRC_PER_VEC = 3,
  parameter int ADDR_W      = 8,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STRIDE  = 8,
  parameter int STACK_DEPTH = 3,
  localparam int NUM_SRC    = NUM_VEC * SRC_PER_VEC,
  localparam int IDX_W      = $clog2(NUM_VEC),
  localparam int DEPTH_W    = $clog2(STACK_DEPTH + 1),
  localparam int PTR_W      = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   src_flag,
  input  logic [NUM_SRC-1:0]   src_en,
  input  logic [2*NUM_VEC-1:0] vec_level,
  input  logic                 ack,
  input  logic                 reti,
  output logic                 irq,
  output logic [ADDR_W-1:0]    req_addr,
  output logic [ADDR_W-1:0]    svc_addr,
  output logic [1:0]           cur_level,
  output logic [DEPTH_W-1:0]   depth
);

  function automatic logic [1:0] rank_of(input logic [1:0] code);
    return (code == 2'd0) ? 2'd1 : (code == 2'd1) ? 2'd2 : 2'd3;
  endfunction

  logic [NUM_VEC-1:0] pend;
  logic [1:0]         win_rank;
  logic [IDX_W-1:0]   win_idx;
  logic [1:0]         stk [STACK_DEPTH];
  logic               take, pop;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_pend
    assign pend[v] = |(src_flag[v*SRC_PER_VEC +: SRC_PER_VEC] & src_en[v*SRC_PER_VEC +: SRC_PER_VEC]);
  end

  always_comb begin
    win_rank = 2'd0;
    win_idx  = '0;
    for (int v = 0; v < NUM_VEC; v++) begin
      if (pend[v] && rank_of(vec_level[2*v +: 2]) > win_rank) begin
        win_rank = rank_of(vec_level[2*v +: 2]);
        win_idx  = IDX_W'(v);
      end
    end
  end

  assign cur_level = (depth == '0) ? 2'd0 : stk[PTR_W'(depth - 1'b1)];
  assign irq       = win_rank > cur_level;
  assign req_addr  = ADDR_W'(VEC_BASE + VEC_STRIDE * int'(win_idx));
  assign pop       = reti && (depth != '0);
  assign take      = ack && irq && !reti && (depth < DEPTH_W'(STACK_DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth    <= '0;
      svc_addr <= '0;
      for (int i = 0; i < STACK_DEPTH; i++) stk[i] <= 2'd0;
    end else if (pop) begin
      depth <= depth - 1'b1;
    end else if (take) begin
      stk[PTR_W'(depth)] <= win_rank;
      depth              <= depth + 1'b1;
      svc_addr           <= req_addr;
    end
  end

endmodule

module irq_level_arbiter_chk #(
  parameter int ADDR_W      = 8,
  parameter int DEPTH_W     = 2,
  parameter int STACK_DEPTH = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ack,
  input logic               reti,
  input logic               irq,
  input logic [1:0]         win_rank,
  input logic [1:0]         cur_level,
  input logic [DEPTH_W-1:0] depth,
  input logic [ADDR_W-1:0]  svc_addr
);

  AST_TOP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_level == 2'd3) |-> !irq); // R5

  AST_NEST_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (depth > $past(depth)) |-> (cur_level > $past(cur_level))); // R5

  AST_ACK_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq && !reti && depth < DEPTH_W'(STACK_DEPTH)) |=>
      (depth == DEPTH_W'($past(depth) + 1'b1)) && (cur_level == $past(win_rank))); // R6

  AST_RETI_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && depth != '0) |=> (depth == DEPTH_W'($past(depth) - 1'b1))); // R7

  AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq && !reti) |=> ($stable(depth) && $stable(svc_addr))); // R8

  AST_BOTH_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && reti && depth != '0) |=> (depth < $past(depth))); // R9

endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(
  .ADDR_W(ADDR_W), .DEPTH_W(DEPTH_W), .STACK_DEPTH(STACK_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .reti(reti), .irq(irq),
  .win_rank(win_rank), .cur_level(cur_level), .depth(depth), .svc_addr(svc_addr)
);

// File: tb/irq_level_arbiter_bench.sv
module irq_level_arbiter_bench;
  localparam int PER = 10;
  localparam logic [29:0] ALL = 30'h3FFFFFFF;

  // {flags, enables, levels, expected irq, expected req_addr}
  localparam logic [88:0] TAB [9] = '{
    {30'h0,        ALL,          20'h0,     1'b0, 8'h00},
    {30'h80,       ALL,          20'h0,     1'b1, 8'h13},
    {30'h80,       30'h3FFFFF7F, 20'h0,     1'b0, 8'h00},
    {30'h10000010, ALL,          20'h0,     1'b1, 8'h0B},
    {30'h10000010, ALL,          20'h80000, 1'b1, 8'h4B},
    {30'h20000001, ALL,          20'h40001, 1'b1, 8'h03},
    {30'h4,        30'h4,        20'h0,     1'b1, 8'h03},
    {30'h04020000, ALL,          20'h20C00, 1'b1, 8'h2B},
    {30'h08000000, ALL,          20'h0,     1'b1, 8'h4B}
  };

  logic        clk = 0, rst_n = 0, ack = 0, reti = 0;
  logic [29:0] src_flag = '0, src_en = '0;
  logic [19:0] vec_level = '0;
  logic        irq;
  logic [7:0]  req_addr, svc_addr;
  logic [1:0]  cur_level, depth;
  int checks = 0, errors = 0;

  irq_level_arbiter u_irq_level_arbiter (
    .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .src_en(src_en),
    .vec_level(vec_level), .ack(ack), .reti(reti), .irq(irq),
    .req_addr(req_addr), .svc_addr(svc_addr), .cur_level(cur_level), .depth(depth)
  );

  always #(PER/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic state(input string tag, input int d, input int lvl, input int ir);
    chk({tag, " depth"}, int'(depth), d);
    chk({tag, " cur_level"}, int'(cur_level), lvl);
    chk({tag, " irq"}, int'(irq), ir);
  endtask

  task automatic pulse(input logic a, input logic r);
    ack = a; reti = r;
    @(negedge clk);
    ack = 0; reti = 0;
    #1;
  endtask

  initial begin
    #(PER * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1;
    state("R10 reset", 0, 0, 0);
    chk("R10 svc_addr", int'(svc_addr), 0);

    for (int i = 0; i < 9; i++) begin
      src_flag  = TAB[i][88:59];
      src_en    = TAB[i][58:29];
      vec_level = TAB[i][28:9];
      #1;
      chk($sformatf("R2/R3/R4 row %0d irq", i), int'(irq), int'(TAB[i][8]));
      if (TAB[i][8]) chk($sformatf("R1/R4 row %0d req_addr", i), int'(req_addr), int'(TAB[i][7:0]));
      @(negedge clk);
    end

    src_flag  = 30'h00100401;
    vec_level = 20'h02040;
    src_en    = 30'h1;
    #1;
    chk("R1 req_addr vec0", int'(req_addr), 8'h03);
    pulse(1, 0);
    state("R6 push low", 1, 1, 0);
    chk("R6 svc_addr", int'(svc_addr), 8'h03);

    src_en = 30'h401;
    #1;
    state("R5 high over low", 1, 1, 1);
    chk("R1 req_addr vec3", int'(req_addr), 8'h1B);
    pulse(1, 0);
    state("R6 push high", 2, 2, 0);
    chk("R6 svc_addr high", int'(svc_addr), 8'h1B);

    src_en = 30'h100401;
    #1;
    chk("R1 req_addr vec6", int'(req_addr), 8'h33);
    pulse(1, 0);
    state("R5 full stack blocks", 3, 3, 0);

    pulse(1, 0);
    state("R8 idle ack", 3, 3, 0);
    chk("R8 svc_addr kept", int'(svc_addr), 8'h33);

    pulse(0, 1);
    state("R7 pop to high", 2, 2, 1);
    src_en = 30'h401;
    #1;
    chk("R5 equal level held", int'(irq), 0);
    pulse(0, 1);
    state("R7 pop to low", 1, 1, 1);

    pulse(1, 1);
    state("R9 reti wins", 0, 0, 1);
    chk("R9 svc_addr kept", int'(svc_addr), 8'h33);

    pulse(0, 1);
    state("R7 reti at depth 0", 0, 0, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule